// File: doc/BRIEF.md
# Synaptic Gating Euler Stepper

This block holds the synaptic gating variable `s` of one synapse population and advances it by one forward-Euler time step whenever a step strobe arrives. The caller supplies a precomputed hyperbolic tangent of the presynaptic membrane voltage scaled by one tenth. The block turns it into a normalized transmitter level `T = (1 + tanh)/2` and evaluates the rate `ds/dt = T*(1 - s)/tauRise - s/tauDecay`. It scales that rate by the time step, adds it to the stored state and clamps the result to the unit interval.

A receptor-class select input picks between two pairs of time constants. The fast excitatory class has a rise time of 0.2 ms and a decay time of 2 ms. The slower inhibitory class has a rise time of 0.5 ms and a decay time of 10 ms. Both divisions are done by multiplying with stored reciprocals. An initialisation strobe loads an externally supplied value into the state register through a multiplexer, so that a time-multiplexed engine can swap neuron contexts in and out.

All data are signed fixed point with `F` fractional bits (Q2.14 by default, so 1.0 is 16384). The time step is the parameter `DT_Q` in the same scale; the default of 164 is about 0.01 ms.

Top module: `syn_gate_euler`

## Requirements
- R1: While `rstN` is low, and after it is released until the first strobe, `sOut` is 0.
- R2: When `initReq` is high at a rising clock edge, `sOut` equals the `initVal` sampled at that edge from the next cycle on, loaded bit for bit without clamping.
- R3: When `initReq` and `stepReq` are both high in the same cycle, the initial value is loaded and no integration step takes place.
- R4: In a cycle with neither strobe high, `sOut` keeps its value whatever `tanhIn`, `initVal` and `receptorInh` do.
- R5: The transmitter level is `T = (16384 + tanhIn) >>> 1`, with `tanhIn` a signed value in [-16384, 16384]. A value of -16384 gives T = 0 and 16384 gives T = 1.0.
- R6: With `receptorInh` = 0 the rise and decay reciprocals are 5.0 (81920) and 0.5 (8192). With `receptorInh` = 1 they are 2.0 (32768) and 0.1 (1638).
- R7: On a step the block computes `a = (T*(16384 - s)) >>> 14`, `rise = (a*kRise) >>> 14`, `decay = (s*kDecay) >>> 14` and `inc = ((rise - decay)*DT_Q) >>> 14`. The value `s + inc` is then written back. Every `>>>` is an arithmetic shift that rounds toward minus infinity.
- R8: The value written by a step is clamped to [0, 16384]: a negative sum becomes 0 and a sum above 16384 becomes 16384.
- R9: A step with T = 0, starting from a state inside [0, 16384], never raises `s`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| initReq | input | 1 | Load `initVal` into the state register |
| stepReq | input | 1 | Advance the state by one Euler step |
| receptorInh | input | 1 | 0 selects the excitatory time constants, 1 the inhibitory ones |
| tanhIn | input | W | Signed tanh of the presynaptic voltage over 10, F fractional bits |
| initVal | input | W | Signed initial value of the gating variable |
| sOut | output | W | Current gating variable, signed, F fractional bits |

## Verification
Loading an initial value and taking an integration step can be requested in the same cycle. The bench provokes this by raising both strobes together, with a transmitter level that would move the state visibly. It then judges the outcome by requiring `sOut` to equal the supplied initial value exactly in the following cycle. The main sweep loads every state on a grid, steps it once for every tanh value on a grid and both receptor classes, and compares each result with an arithmetic model. A second instance with a large time step drives the sums past both clamp bounds.

// File: rtl/syn_gate_pkg.sv
package syn_gate_pkg;

  typedef struct packed {
    logic load;
    logic advance;
  } gateCtl_t;

  // Reciprocal of the rise time constant, scaled by 2**f
  function automatic longint riseCoef(input logic inh, input int f);
    return inh ? (longint'(2) << f) : (longint'(5) << f);
  endfunction

  // Reciprocal of the decay time constant, scaled by 2**f
  function automatic longint decayCoef(input logic inh, input int f);
    return inh ? (((longint'(1) << f) + 5) / 10) : (longint'(1) << (f - 1));
  endfunction

endpackage

// File: rtl/syn_gate_ctrl.sv
module syn_gate_ctrl
  import syn_gate_pkg::*;
(
  input  logic     initReq,
  input  logic     stepReq,
  output gateCtl_t ctl
);
  // The load strobe wins over the step strobe
  always_comb begin
    ctl.load    = initReq;
    ctl.advance = stepReq & ~initReq;
  end
endmodule

// File: rtl/syn_gate_dp.sv
module syn_gate_dp
  import syn_gate_pkg::*;
#(
  parameter int W    = 16,
  parameter int F    = 14,
  parameter int DT_Q = 164
) (
  input  logic                clk,
  input  logic                rstN,
  input  gateCtl_t            ctl,
  input  logic                receptorInh,
  input  logic signed [W-1:0] tanhIn,
  input  logic signed [W-1:0] initVal,
  output logic signed [W-1:0] sOut
);
  localparam int PW = 4 * W;
  localparam logic signed [PW-1:0] ONE     = PW'(longint'(1) << F);
  localparam logic signed [PW-1:0] DT_W    = PW'(longint'(DT_Q));
  localparam logic signed [PW-1:0] K_RISE_E  = PW'(riseCoef(1'b0, F));
  localparam logic signed [PW-1:0] K_RISE_I  = PW'(riseCoef(1'b1, F));
  localparam logic signed [PW-1:0] K_DECAY_E = PW'(decayCoef(1'b0, F));
  localparam logic signed [PW-1:0] K_DECAY_I = PW'(decayCoef(1'b1, F));

  logic signed [W-1:0]  sReg;
  logic signed [PW-1:0] sW, tanhW, transm, prodA, kRise, kDecay;
  logic signed [PW-1:0] riseTerm, decayTerm, deriv, incr, sumW;
  logic signed [W-1:0]  stepVal;

  always_comb begin
    sW        = PW'(sReg);
    tanhW     = PW'(tanhIn);
    kRise     = receptorInh ? K_RISE_I  : K_RISE_E;
    kDecay    = receptorInh ? K_DECAY_I : K_DECAY_E;
    transm    = (ONE + tanhW) >>> 1;
    prodA     = (transm * (ONE - sW)) >>> F;
    riseTerm  = (prodA * kRise) >>> F;
    decayTerm = (sW * kDecay) >>> F;
    deriv     = riseTerm - decayTerm;
    incr      = (deriv * DT_W) >>> F;
    sumW      = sW + incr;
    if (sumW < 0)        stepVal = '0;
    else if (sumW > ONE) stepVal = W'(ONE);
    else                 stepVal = W'(sumW);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            sReg <= '0;
    else if (ctl.load)    sReg <= initVal;
    else if (ctl.advance) sReg <= stepVal;
  end

  assign sOut = sReg;
endmodule

// File: rtl/syn_gate_euler.sv
module syn_gate_euler
  import syn_gate_pkg::*;
#(
  parameter int W    = 16,
  parameter int F    = 14,
  parameter int DT_Q = 164
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                initReq,
  input  logic                stepReq,
  input  logic                receptorInh,
  input  logic signed [W-1:0] tanhIn,
  input  logic signed [W-1:0] initVal,
  output logic signed [W-1:0] sOut
);
  gateCtl_t ctl;

  syn_gate_ctrl ctrl_i (
    .initReq (initReq),
    .stepReq (stepReq),
    .ctl     (ctl)
  );

  syn_gate_dp #(.W(W), .F(F), .DT_Q(DT_Q)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .receptorInh (receptorInh),
    .tanhIn      (tanhIn),
    .initVal     (initVal),
    .sOut        (sOut)
  );
endmodule

// File: rtl/syn_gate_euler_chk.sv
module syn_gate_euler_chk #(
  parameter int W = 16,
  parameter int F = 14
) (
  input logic                clk,
  input logic                rstN,
  input logic                initReq,
  input logic                stepReq,
  input logic signed [W-1:0] tanhIn,
  input logic signed [W-1:0] initVal,
  input logic signed [W-1:0] sOut
);
  localparam logic signed [W-1:0] ONE = W'(longint'(1) << F);

  always_comb begin
    if (!rstN) AST_RESET_ZERO: assert (sOut == '0); // R1
  end

  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    initReq |=> sOut == $past(initVal)); // R2

  AST_INIT_OVER_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (initReq && stepReq) |=> sOut == $past(initVal)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!initReq && !stepReq) |=> $stable(sOut)); // R4

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (stepReq && !initReq) |=> (sOut >= 0 && sOut <= ONE)); // R8

  AST_NO_RISE_AT_ZERO_T: assert property (@(posedge clk) disable iff (!rstN)
    (stepReq && !initReq && tanhIn == -ONE && sOut >= 0 && sOut <= ONE)
      |=> sOut <= $past(sOut)); // R9
endmodule

bind syn_gate_euler syn_gate_euler_chk #(.W(W), .F(F)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .initReq (initReq),
  .stepReq (stepReq),
  .tanhIn  (tanhIn),
  .initVal (initVal),
  .sOut    (sOut)
);

// File: tb/syn_gate_euler_tb_top.sv
`timescale 1ns/1ps
module syn_gate_euler_tb_top;
  localparam int  W      = 16;
  localparam int  F      = 14;
  localparam int  DT_A   = 164;
  localparam int  DT_B   = 65536;
  localparam longint ONE = 16384;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initReq = 1'b0, stepReq = 1'b0, receptorInh = 1'b0;
  logic signed [W-1:0] tanhIn = '0, initVal = '0;
  logic signed [W-1:0] sOutA, sOutB;

  int vecCnt = 0;
  int failCnt = 0;
  bit doneFlag = 1'b0;

  always #2 clk = ~clk;

  syn_gate_euler #(.W(W), .F(F), .DT_Q(DT_A)) dut_i (
    .clk(clk), .rstN(rstN), .initReq(initReq), .stepReq(stepReq),
    .receptorInh(receptorInh), .tanhIn(tanhIn), .initVal(initVal), .sOut(sOutA));

  syn_gate_euler #(.W(W), .F(F), .DT_Q(DT_B)) dutBig_i (
    .clk(clk), .rstN(rstN), .initReq(initReq), .stepReq(stepReq),
    .receptorInh(receptorInh), .tanhIn(tanhIn), .initVal(initVal), .sOut(sOutB));

  // Expected next state from R5..R8
  function automatic longint model(longint s, longint t, bit inh, longint dt);
    longint tr, a, kr, kd, rise, dec, inc, n;
    tr   = (ONE + t) >>> 1;
    a    = (tr * (ONE - s)) >>> F;
    kr   = inh ? 32768 : 81920;
    kd   = inh ? 1638 : 8192;
    rise = (a * kr) >>> F;
    dec  = (s * kd) >>> F;
    inc  = ((rise - dec) * dt) >>> F;
    n    = s + inc;
    if (n < 0) n = 0;
    if (n > ONE) n = ONE;
    return n;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    vecCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
      $finish;
    end
  end

  initial begin
    longint expA, expB, sPrev;
    string tag;
    @(negedge clk);
    check("R1", sOutA, 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    cyc();
    check("R1", sOutA, 0);
    check("R1", sOutB, 0);

    // Priority: both strobes together, step would move state away
    initVal = 16'sd5000; tanhIn = 16'sd16384; receptorInh = 1'b0;
    initReq = 1'b1; stepReq = 1'b1;
    cyc();
    initReq = 1'b0; stepReq = 1'b0;
    check("R3", sOutA, 5000);
    check("R3", sOutB, 5000);

    // Idle hold with changing inputs
    for (int k = 0; k < 6; k++) begin
      tanhIn = 16'(k * 3000 - 8000); initVal = 16'(k * 777); receptorInh = k[0];
      cyc();
      check("R4", sOutA, 5000);
      check("R4", sOutB, 5000);
    end

    // Unclamped init load, out of range value
    initVal = -16'sd300; initReq = 1'b1;
    cyc();
    initReq = 1'b0;
    check("R2", sOutA, -300);

    // Sweep: load grid state, step with grid tanh and both receptors
    for (int si = 0; si <= 16; si++) begin
      for (int ti = 0; ti <= 16; ti++) begin
        for (int ri = 0; ri < 2; ri++) begin
          sPrev = si * 1024;
          initVal = 16'(sPrev); initReq = 1'b1; stepReq = 1'b0;
          cyc();
          check("R2", sOutA, sPrev);
          initReq = 1'b0; stepReq = 1'b1;
          tanhIn = 16'(ti * 2048 - 16384); receptorInh = ri[0];
          expA = model(sPrev, longint'(tanhIn), ri[0], DT_A);
          expB = model(sPrev, longint'(tanhIn), ri[0], DT_B);
          cyc();
          stepReq = 1'b0;
          if (ti == 0)       tag = "R9";
          else if (ti == 16) tag = "R5";
          else if (ri == 1)  tag = "R6";
          else               tag = "R7";
          check(tag, sOutA, expA);
          check((expB == 0 || expB == ONE) ? "R8" : tag, sOutB, expB);
        end
      end
    end

    // Consecutive steps from zero, inhibitory, mid tanh
    initVal = '0; initReq = 1'b1;
    cyc();
    initReq = 1'b0;
    expA = 0;
    for (int k = 0; k < 8; k++) begin
      stepReq = 1'b1; receptorInh = 1'b1; tanhIn = 16'sd4000;
      expA = model(expA, 4000, 1'b1, DT_A);
      cyc();
      check("R7", sOutA, expA);
    end
    stepReq = 1'b0;

    // Explicit clamp corners on the large step instance
    initVal = '0; initReq = 1'b1;
    cyc();
    initReq = 1'b0; stepReq = 1'b1; tanhIn = 16'sd16384; receptorInh = 1'b0;
    cyc();
    stepReq = 1'b0;
    check("R8", sOutB, ONE);

    doneFlag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end
endmodule